// File: doc/BRIEF.md
# Three-Stage Pipelined Datapath with Operand Bypass

This block is a small in-order, register-to-register datapath built from three stages. The fetch stage (I) captures one instruction word per clock from a plain instruction port. The middle stage (A) decodes the word, reads the register file and computes either an ALU result or a memory address. The final stage (E) writes the destination register or the internal data memory. The register file holds eight 16-bit registers. Every one of them, register 0 included, is an ordinary register.

A result can reach the instruction directly behind it before it is written back. A bypass from the E-stage result buffer feeds both A-stage operand multiplexers and the store-data path. A loaded word exists only in E, so a dependent instruction directly after a load is held in A for one cycle, and a bubble enters E. The register contents and the stall indicator come out on ports so that the datapath can be checked from outside.

Top module: `pipe3_core`

## Requirements
- R1: After reset, all eight registers read zero, `stall_o` is low and `instr_ready_o` is high.
- R2: An instruction word is {op[15:12], rd[11:9], rs1[8:6], rs2[5:3], imm[2:0]}. Op 1 writes rs1+rs2 to rd. Op 2 writes rs1-rs2 to rd. Op 3 writes rs1+1 to rd. All arithmetic is modulo 2^16.
- R3: An ALU result is forwarded to either or both source operands of the very next instruction, with no stall.
- R4: Op 4 (load) writes memory word (rs1+imm) mod 16 into rd. Op 5 (store) writes the value of rs2 to memory word (rs1+imm) mod 16. The immediate is unsigned.
- R5: When the instruction directly after a load reads the load's rd through any source it uses, `stall_o` is high for exactly one cycle and `instr_ready_o` is low in that cycle. The dependent instruction then sees the loaded value.
- R6: An instruction after a load that does not read the load's rd proceeds without a stall.
- R7: During a stall, the held instruction stays in A, no word is accepted from the port, and the bubble writes neither registers nor memory.
- R8: The store data operand (rs2) is forwarded from the preceding ALU result, just as the ALU operands are.
- R9: Op 0 and ops 6 to 15 change no register and no memory word.
- R10: Register 0 can be written, and it is bypassed like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word offered to the fetch stage |
| instr_ready_o | output | 1 | High when `instr_i` is captured at the next edge |
| stall_o | output | 1 | High while a load-use interlock holds the A stage |
| rf_flat_o | output | 128 | Register contents; register n is at bits [16n+15:16n] |

## Verification
A word offered while `instr_ready_o` is high is in A after the first rising edge and in E after the second. Its register write is visible on `rf_flat_o` after the third edge. `stall_o` rises in the cycle after the edge that captured the dependent word. The bench drives inputs and samples outputs on falling edges. Its in-order reference model retires each instruction in the cycle that the three-stage timing gives, and it predicts the stall from the load now in E and the word now in A. Register contents, the stall indicator and the ready flag are compared on every cycle, and the total stall count is checked at the end.

// File: rtl/pipe3_pkg.sv
package pipe3_pkg;

  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int REG_W   = 3;
  localparam int IMM_W   = 3;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP   = 4'd0,
    OP_ADD   = 4'd1,
    OP_SUB   = 4'd2,
    OP_INC   = 4'd3,
    OP_LOAD  = 4'd4,
    OP_STORE = 4'd5
  } op_e;

  typedef struct packed {
    logic [OPC_W-1:0] op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [IMM_W-1:0] imm;
  } instr_t;

  // Unknown opcodes collapse to a no-op
  function automatic op_e decode_op(logic [OPC_W-1:0] raw);
    case (raw)
      4'd1:    return OP_ADD;
      4'd2:    return OP_SUB;
      4'd3:    return OP_INC;
      4'd4:    return OP_LOAD;
      4'd5:    return OP_STORE;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic uses_src1(op_e op);
    return (op != OP_NOP);
  endfunction

  function automatic logic uses_src2(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_STORE);
  endfunction

  function automatic logic writes_reg(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_LOAD);
  endfunction

  // Result available at the E-stage buffer (bypassable)
  function automatic logic result_in_buffer(op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC);
  endfunction

endpackage

// File: rtl/pipe3_regfile.sv
module pipe3_regfile #(
  parameter int XLEN = 16,
  parameter int NREG = 8,
  localparam int RW = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RW-1:0]        waddr,
  input  logic [XLEN-1:0]      wdata,
  input  logic [RW-1:0]        raddr1,
  input  logic [RW-1:0]        raddr2,
  output logic [XLEN-1:0]      rdata1,
  output logic [XLEN-1:0]      rdata2,
  output logic [NREG*XLEN-1:0] flat_o
);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata1 = regs[raddr1];
  assign rdata2 = regs[raddr2];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_o[g*XLEN +: XLEN] = regs[g];
  end

endmodule

// File: rtl/pipe3_dmem.sv
module pipe3_dmem #(
  parameter int XLEN  = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata
);

  logic [XLEN-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      words[addr] <= wdata;
    end
  end

  assign rdata = words[addr];

endmodule

// File: rtl/pipe3_bypass.sv
module pipe3_bypass
  import pipe3_pkg::*;
#(
  parameter int XLEN = 16,
  parameter int RW   = 3
) (
  input  op_e             a_op,
  input  logic [RW-1:0]   a_rs1,
  input  logic [RW-1:0]   a_rs2,
  input  logic [XLEN-1:0] rf_d1,
  input  logic [XLEN-1:0] rf_d2,
  input  op_e             e_op,
  input  logic [RW-1:0]   e_rd,
  input  logic [XLEN-1:0] e_val,
  output logic [XLEN-1:0] opnd1,
  output logic [XLEN-1:0] opnd2,
  output logic            fwd1,
  output logic            fwd2,
  output logic            load_use
);

  localparam int NSRC = 2;

  logic [RW-1:0]   src  [NSRC];
  logic            need [NSRC];
  logic [XLEN-1:0] rfd  [NSRC];
  logic [XLEN-1:0] sel  [NSRC];
  logic            byp  [NSRC];
  logic            dep  [NSRC];

  assign src[0]  = a_rs1;
  assign src[1]  = a_rs2;
  assign need[0] = uses_src1(a_op);
  assign need[1] = uses_src2(a_op);
  assign rfd[0]  = rf_d1;
  assign rfd[1]  = rf_d2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign dep[g] = need[g] && (src[g] == e_rd);
    assign byp[g] = dep[g] && result_in_buffer(e_op);
    assign sel[g] = byp[g] ? e_val : rfd[g];
  end

  assign opnd1    = sel[0];
  assign opnd2    = sel[1];
  assign fwd1     = byp[0];
  assign fwd2     = byp[1];
  assign load_use = (e_op == OP_LOAD) && (dep[0] || dep[1]);

endmodule

// File: rtl/pipe3_core.sv
module pipe3_core
  import pipe3_pkg::*;
#(
  parameter int XLEN      = 16,
  parameter int NREG      = 8,
  parameter int MEM_DEPTH = 16,
  localparam int RW = $clog2(NREG),
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [INSTR_W-1:0]   instr_i,
  output logic                 instr_ready_o,
  output logic                 stall_o,
  output logic [NREG*XLEN-1:0] rf_flat_o
);

  // A-stage compute: ALU result or effective address
  function automatic logic [XLEN-1:0] a_compute(op_e op, logic [XLEN-1:0] x,
                                                logic [XLEN-1:0] y, logic [IMM_W-1:0] imm);
    case (op)
      OP_ADD:            return x + y;
      OP_SUB:            return x - y;
      OP_INC:            return x + XLEN'(1);
      OP_LOAD, OP_STORE: return x + XLEN'(imm);
      default:           return '0;
    endcase
  endfunction

  // I stage register (instruction held for A)
  instr_t          a_q;
  op_e             a_op;
  logic            stall;

  // E stage result buffer
  op_e             e_op;
  logic [RW-1:0]   e_rd;
  logic [XLEN-1:0] e_val;
  logic [XLEN-1:0] e_sdata;

  logic [XLEN-1:0] rf_d1, rf_d2, opnd1, opnd2, mem_rd, wb_data;
  logic            fwd1, fwd2, rf_we, mem_we;

  assign a_op = decode_op(a_q.op);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
    end else if (!stall) begin
      a_q <= instr_t'(instr_i);
    end
  end

  pipe3_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (e_rd),
    .wdata  (wb_data),
    .raddr1 (a_q.rs1),
    .raddr2 (a_q.rs2),
    .rdata1 (rf_d1),
    .rdata2 (rf_d2),
    .flat_o (rf_flat_o)
  );

  pipe3_bypass #(.XLEN(XLEN), .RW(RW)) u_byp (
    .a_op     (a_op),
    .a_rs1    (a_q.rs1),
    .a_rs2    (a_q.rs2),
    .rf_d1    (rf_d1),
    .rf_d2    (rf_d2),
    .e_op     (e_op),
    .e_rd     (e_rd),
    .e_val    (e_val),
    .opnd1    (opnd1),
    .opnd2    (opnd2),
    .fwd1     (fwd1),
    .fwd2     (fwd2),
    .load_use (stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_op    <= OP_NOP;
      e_rd    <= '0;
      e_val   <= '0;
      e_sdata <= '0;
    end else if (stall) begin
      e_op    <= OP_NOP;
    end else begin
      e_op    <= a_op;
      e_rd    <= a_q.rd;
      e_val   <= a_compute(a_op, opnd1, opnd2, a_q.imm);
      e_sdata <= opnd2;
    end
  end

  assign mem_we  = (e_op == OP_STORE);
  assign rf_we   = writes_reg(e_op);
  assign wb_data = (e_op == OP_LOAD) ? mem_rd : e_val;

  pipe3_dmem #(.XLEN(XLEN), .DEPTH(MEM_DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .addr  (e_val[AW-1:0]),
    .wdata (e_sdata),
    .rdata (mem_rd)
  );

  assign instr_ready_o = !stall;
  assign stall_o       = stall;

endmodule

// File: rtl/pipe3_core_chk.sv
module pipe3_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic [3:0]  e_op,
  input logic [15:0] a_q,
  input logic        rf_we,
  input logic        mem_we,
  input logic        fwd1,
  input logic        fwd2
);

  logic a_is_noop;
  assign a_is_noop = (a_q[15:12] == 4'd0) || (a_q[15:12] > 4'd5);

  // R5: an interlock only arises behind a load sitting in E
  p_stall_behind_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (e_op == 4'd4));

  // R5: one bubble always resolves the dependency
  p_single_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R7: the held instruction is kept in A during the stall
  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(a_q));

  // R7: the bubble writes nothing
  p_bubble_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!rf_we && !mem_we));

  // R9: no-op opcodes never reach a write port
  p_noop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_is_noop && !stall) |=> (!rf_we && !mem_we));

  // R3: a bypass never coincides with an interlock
  p_fwd_no_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd1 || fwd2) |-> !stall);

endmodule

bind pipe3_core pipe3_core_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .stall  (stall),
  .e_op   (e_op),
  .a_q    (a_q),
  .rf_we  (rf_we),
  .mem_we (mem_we),
  .fwd1   (fwd1),
  .fwd2   (fwd2)
);

// File: tb/pipe3_core_bench.sv
`timescale 1ns/1ps
module pipe3_core_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  instr_i = '0;
  logic         instr_ready_o;
  logic         stall_o;
  logic [127:0] rf_flat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pipe3_core u_pipe3_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_i       (instr_i),
    .instr_ready_o (instr_ready_o),
    .stall_o       (stall_o),
    .rf_flat_o     (rf_flat_o)
  );

  // Behavioural reference state
  logic [15:0] m_rf  [8];
  logic [15:0] m_mem [16];
  logic [15:0] prog  [$];

  function automatic logic [15:0] mk(int op, int rd, int rs1, int rs2, int imm);
    return {4'(op), 3'(rd), 3'(rs1), 3'(rs2), 3'(imm)};
  endfunction

  function automatic bit reads_reg(logic [15:0] w, logic [2:0] r);
    case (w[15:12])
      4'd1, 4'd2, 4'd5: return (w[8:6] == r) || (w[5:3] == r);
      4'd3, 4'd4:       return (w[8:6] == r);
      default:          return 0;
    endcase
  endfunction

  task automatic retire(logic [15:0] w);
    logic [15:0] x, y;
    logic [3:0]  ad;
    x  = m_rf[w[8:6]];
    y  = m_rf[w[5:3]];
    ad = 4'(x + 16'(w[2:0]));
    case (w[15:12])
      4'd1: m_rf[w[11:9]] = x + y;
      4'd2: m_rf[w[11:9]] = x - y;
      4'd3: m_rf[w[11:9]] = x + 16'd1;
      4'd4: m_rf[w[11:9]] = m_mem[ad];
      4'd5: m_mem[ad]     = y;
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int r = 0; r < 8; r++)
      check($sformatf("%s rf[%0d]", tag, r), rf_flat_o[16*r +: 16], m_rf[r]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=hang expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] a_m, e_m, cur;
    bit exp_stall;
    int p, drain, seen_stalls;

    for (int r = 0; r < 8; r++) m_rf[r] = '0;
    for (int k = 0; k < 16; k++) m_mem[k] = '0;

    prog.push_back(mk(3,1,1,0,0)); // R2 INC r1 -> 1
    prog.push_back(mk(3,1,1,0,0)); // R3 INC forwarded -> 2
    prog.push_back(mk(1,2,1,1,0)); // R3 ADD both sources forwarded -> 4
    prog.push_back(mk(2,3,2,1,0)); // R2 SUB -> 2
    prog.push_back(mk(3,0,0,0,0)); // R10 register 0 written -> 1
    prog.push_back(mk(1,4,0,3,0)); // R10 r0 bypassed -> 3
    prog.push_back(mk(2,5,2,0,0)); // R2 SUB -> 3
    prog.push_back(mk(5,0,1,5,1)); // R8 STORE mem[3]=r5 forwarded data
    prog.push_back(mk(4,6,0,0,2)); // R4 LOAD r6=mem[3]
    prog.push_back(mk(1,7,6,6,0)); // R5 load-use stall -> 6
    prog.push_back(mk(5,0,4,7,3)); // R8 STORE mem[6]=r7
    prog.push_back(mk(4,6,1,0,4)); // R4 LOAD r6=mem[6]
    prog.push_back(mk(3,3,3,0,0)); // R6 independent after load, no stall
    prog.push_back(mk(1,7,6,3,0)); // R6 distance two, no stall -> 9
    prog.push_back(mk(7,1,1,1,0)); // R9 no-op opcode
    prog.push_back(mk(15,2,2,2,7));// R9 no-op opcode
    prog.push_back(mk(2,5,0,2,0)); // R2 wrap 1-4 = FFFD
    prog.push_back(mk(5,0,5,7,7)); // R4 address wrap -> mem[4]=9
    prog.push_back(mk(4,2,0,0,3)); // R4 LOAD r2=mem[4]
    prog.push_back(mk(5,0,0,2,0)); // R5 stall through rs2 of a store
    prog.push_back(mk(4,4,0,0,0)); // R4 LOAD r4=mem[1]

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 stall_o", 16'(stall_o), 16'd0);
    check("R1 instr_ready_o", 16'(instr_ready_o), 16'd1);
    compare_all("R1");

    a_m = '0; e_m = '0; exp_stall = 0;
    p = 0; drain = 0; seen_stalls = 0;
    cur = '0;
    while (p < prog.size() || drain < 6) begin
      // R5 R6 R3 stall and ready comparison each cycle
      check("R5 R6 stall_o", 16'(stall_o), 16'(exp_stall));
      check("R7 instr_ready_o", 16'(instr_ready_o), 16'(!exp_stall));
      compare_all("R2 R3 R4 R8 R9 R10");
      if (stall_o) seen_stalls++;
      if (!exp_stall) begin
        if (p < prog.size()) begin
          cur = prog[p];
          p++;
        end else begin
          cur = '0;
          drain++;
        end
        instr_i = cur;
      end
      @(posedge clk);
      retire(e_m);
      if (exp_stall) e_m = '0;
      else begin
        e_m = a_m;
        a_m = cur;
      end
      exp_stall = (e_m[15:12] == 4'd4) && reads_reg(a_m, e_m[11:9]);
      @(negedge clk);
    end

    // R5 exactly two single-cycle interlocks in the program
    check("R5 stall count", 16'(seen_stalls), 16'd2);
    // R4 R5 final loaded values
    check("R5 r2 loaded", rf_flat_o[16*2 +: 16], 16'd9);
    check("R4 r4 loaded", rf_flat_o[16*4 +: 16], 16'd9);
    check("R6 r7 sum", rf_flat_o[16*7 +: 16], 16'd9);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule